// File: doc/BRIEF.md
# Word-Serial Multiply-Accumulate Multiplier

This block forms the full 512-bit unsigned product of two 256-bit operands with one 16×16 multiplier feeding a wide accumulator. Each operand is viewed as sixteen 16-bit words. The block visits the partial products column by column (product scanning). All pairs of word indices whose sum equals the column number are accumulated in one running sum. At the boundary between columns, the low 16 bits of the sum become one result word, and the rest of the sum, shifted down by 16, seeds the next column. Because of this, only one narrow multiplier and a 32-entry, 16-bit word memory are needed.

A controller holds the block idle for as long as the `hold` input is high. The first clock edge that sees `hold` low starts a run. After a fixed number of cycles, `done` pulses for one cycle. The product can then be read a word at a time through a registered read port. The operands must stay stable from the start of a run until `done`. Raising `hold` during a run abandons that run.

Top module: `wordser_mul`

## Requirements
- R1: After reset, `done` is low and the block is idle until it sees `hold` low at a clock edge.
- R2: While `hold` is high, `done` stays low and the result memory keeps its contents, even when the operands change.
- R3: The first rising edge that samples `hold` low counts as cycle 1. `done` is high for exactly one cycle, following the 259th rising edge: 256 multiply-accumulate steps plus 3 cycles of setup and result writes.
- R4: After `done`, word address k (0 to 31) of the read port holds bits [16k+15:16k] of the unsigned product `op_a * op_b`. Word 0 holds the least significant bits.
- R5: Operands with every bit set, which give the largest column sums and carries, produce the exact product. The accumulator never reaches its top bit.
- R6: `rd_data` shows the word addressed by `rd_addr` at the previous rising edge, which is one cycle of read latency.
- R7: After its pulse, `done` stays low and the product stays unchanged until `hold` has been raised and lowered again.
- R8: Raising `hold` before `done` abandons the run without a `done` pulse. The next run produces a correct product that the abandoned run does not affect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | High keeps the block idle; low starts or continues a run |
| op_a | input | 256 | Multiplicand, unsigned |
| op_b | input | 256 | Multiplier, unsigned |
| done | output | 1 | One-cycle pulse when the product is complete |
| rd_addr | input | 5 | Result word address, 0 = least significant |
| rd_data | output | 16 | Registered result word |

## Verification
The bench runs several operand patterns:
- Zero operands show whether stale memory contents leak into a result.
- The value one times one and one times all-ones show the word ordering and how results are placed in memory.
- All-ones squared drives every column to its largest sum and carries from end to end, so it shows any shortfall in accumulator width or carry handling.
- Products of the top bit by itself place the whole result in the top word, which tests the final write.
- Random operands compare against a product computed in the bench, word by word.

Separate sequences check the exact `done` timing, the one-cycle read latency, that the memory stays unchanged while `hold` is high, and recovery after a run is abandoned.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_TAIL_LO,
        ST_TAIL_HI,
        ST_FIN
    } wsm_state_e;

endpackage

// File: rtl/wsm_seq.sv
// Product-scanning index sequencer: walks column k, word index ia rising,
// ib = k - ia, both kept inside the operand word range.
module wsm_seq #(
    parameter int NWORDS = 16,
    localparam int IDX_W = $clog2(NWORDS),
    localparam int COL_W = $clog2(2 * NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b,
    output logic [COL_W-1:0] col,
    output logic             col_first,
    output logic             col_last,
    output logic             all_last
);

    localparam int LAST_COL = 2 * NWORDS - 2;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [IDX_W-1:0] ia;
    } seq_s;

    seq_s cur_q, cur_d;

    always_comb begin
        int c_now;
        int lo_now;
        int hi_now;
        int lo_nxt;
        c_now  = int'(cur_q.col);
        lo_now = (c_now >= NWORDS) ? c_now - NWORDS + 1 : 0;
        hi_now = (c_now >= NWORDS) ? NWORDS - 1 : c_now;
        lo_nxt = (c_now + 1 >= NWORDS) ? c_now + 2 - NWORDS : 0;

        col_first = (int'(cur_q.ia) == lo_now);
        col_last  = (int'(cur_q.ia) == hi_now);
        all_last  = col_last && (c_now == LAST_COL);
        idx_a     = cur_q.ia;
        idx_b     = IDX_W'(cur_q.col - COL_W'(cur_q.ia));
        col       = cur_q.col;

        cur_d = cur_q;
        if (clear) begin
            cur_d = '0;
        end else if (step) begin
            if (col_last) begin
                cur_d.col = cur_q.col + 1'b1;
                cur_d.ia  = IDX_W'(lo_nxt);
            end else begin
                cur_d.ia = cur_q.ia + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    // A column is entered either at word 0 of A or at the top word of B.
    AST_COL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && col_first) |-> (idx_a == '0 || int'(idx_b) == NWORDS - 1)); // R4

endmodule

// File: rtl/wsm_mac.sv
// Operand word multiplexers and the 16x16 multiply-accumulate unit.
module wsm_mac #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 16,
    parameter int ACC_W  = 40,
    localparam int OP_W  = WORD_W * NWORDS,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             first,
    input  logic [OP_W-1:0]  a_all,
    input  logic [OP_W-1:0]  b_all,
    input  logic [IDX_W-1:0] ia,
    input  logic [IDX_W-1:0] ib,
    output logic [ACC_W-1:0] acc
);

    logic [WORD_W-1:0]   a_words [NWORDS];
    logic [WORD_W-1:0]   b_words [NWORDS];
    logic [WORD_W-1:0]   a_w, b_w;
    logic [2*WORD_W-1:0] prod;
    logic [ACC_W-1:0]    acc_q, acc_d;

    for (genvar g = 0; g < NWORDS; g++) begin : g_split
        assign a_words[g] = a_all[g*WORD_W +: WORD_W];
        assign b_words[g] = b_all[g*WORD_W +: WORD_W];
    end

    always_comb begin
        a_w   = a_words[ia];
        b_w   = b_words[ib];
        prod  = a_w * b_w;
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (en) begin
            // New column: carry what is left above the stored word.
            acc_d = ACC_W'(prod) + (first ? (acc_q >> WORD_W) : acc_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    AST_ACC_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q[ACC_W-1]); // R5

endmodule

// File: rtl/wsm_ram.sv
// Result word store: one write port, one registered read port.
module wsm_ram #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/wordser_mul.sv
module wordser_mul #(
    parameter int OP_W   = 256,
    parameter int WORD_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   hold,
    input  logic [OP_W-1:0]                        op_a,
    input  logic [OP_W-1:0]                        op_b,
    output logic                                   done,
    input  logic [$clog2(2*OP_W/WORD_W)-1:0]       rd_addr,
    output logic [WORD_W-1:0]                      rd_data
);
    import wsm_pkg::*;

    localparam int NWORDS    = OP_W / WORD_W;
    localparam int RES_WORDS = 2 * NWORDS;
    localparam int IDX_W     = $clog2(NWORDS);
    localparam int COL_W     = $clog2(2 * NWORDS);
    localparam int RES_AW    = $clog2(RES_WORDS);
    localparam int RUN_CYC   = NWORDS * NWORDS + 2;
    localparam int CNT_W     = $clog2(RUN_CYC + 2);

    typedef struct packed {
        wsm_state_e        st;
        logic              done;
        logic              wr_pend;
        logic [RES_AW-1:0] wr_idx;
    } ctl_s;

    ctl_s ctl_q, ctl_d;

    logic              seq_clear, seq_step, mac_clear, mac_en;
    logic [IDX_W-1:0]  idx_a, idx_b;
    logic [COL_W-1:0]  col;
    logic              col_first, col_last, all_last;
    logic [ACC_W-1:0]  acc;
    logic              wr_en;
    logic [RES_AW-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;

    wsm_seq #(.NWORDS(NWORDS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_clear),
        .step      (seq_step),
        .idx_a     (idx_a),
        .idx_b     (idx_b),
        .col       (col),
        .col_first (col_first),
        .col_last  (col_last),
        .all_last  (all_last)
    );

    wsm_mac #(.WORD_W(WORD_W), .NWORDS(NWORDS), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mac_clear),
        .en    (mac_en),
        .first (col_first),
        .a_all (op_a),
        .b_all (op_b),
        .ia    (idx_a),
        .ib    (idx_b),
        .acc   (acc)
    );

    wsm_ram #(.WORD_W(WORD_W), .DEPTH(RES_WORDS)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.wr_pend = 1'b0;
        seq_clear     = 1'b0;
        seq_step      = 1'b0;
        mac_clear     = 1'b0;
        mac_en        = 1'b0;

        // Finished column is written one cycle after its last product.
        wr_en   = ctl_q.wr_pend;
        wr_addr = ctl_q.wr_idx;
        wr_data = acc[WORD_W-1:0];

        unique case (ctl_q.st)
            ST_IDLE: begin
                seq_clear = 1'b1;
                mac_clear = 1'b1;
                if (!hold) ctl_d.st = ST_MAC;
            end
            ST_MAC: begin
                seq_step      = 1'b1;
                mac_en        = 1'b1;
                ctl_d.wr_pend = col_last;
                ctl_d.wr_idx  = RES_AW'(col);
                if (all_last) ctl_d.st = ST_TAIL_LO;
            end
            ST_TAIL_LO: begin
                ctl_d.st = ST_TAIL_HI;
            end
            ST_TAIL_HI: begin
                wr_en      = 1'b1;
                wr_addr    = RES_AW'(RES_WORDS - 1);
                wr_data    = acc[2*WORD_W-1:WORD_W];
                ctl_d.st   = ST_FIN;
                ctl_d.done = 1'b1;
            end
            ST_FIN: begin
                ctl_d.st = ST_FIN;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (hold) begin
            ctl_d.st      = ST_IDLE;
            ctl_d.done    = 1'b0;
            ctl_d.wr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_IDLE;
            ctl_q.done    <= 1'b0;
            ctl_q.wr_pend <= 1'b0;
            ctl_q.wr_idx  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done = ctl_q.done;

    // Cycles since leaving idle, used only by the run-length check.
    logic [CNT_W-1:0] run_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              run_cnt_q <= '0;
        else if (ctl_q.st == ST_IDLE)            run_cnt_q <= '0;
        else if (int'(run_cnt_q) < RUN_CYC + 1)  run_cnt_q <= run_cnt_q + 1'b1;
    end

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !done); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(run_cnt_q) == RUN_CYC)); // R3

    AST_TOP_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TAIL_HI) |-> ((acc >> (2*WORD_W)) == '0)); // R4

    AST_NO_LATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ctl_q.st != ST_IDLE && ctl_q.st != ST_FIN)); // R7

endmodule

// File: tb/wordser_mul_test.sv
module wordser_mul_test;

    localparam int CLK_PERIOD = 10;
    localparam int NRES       = 32;
    localparam int RUN_LEN    = 259;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hold = 1'b1;
    logic [255:0] op_a = '0;
    logic [255:0] op_b = '0;
    logic         done;
    logic [4:0]   rd_addr = '0;
    logic [15:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int mon_cnt = 0;
    logic [511:0] exp_q [$];
    logic [511:0] last_prod = '0;

    wordser_mul uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .op_a    (op_a),
        .op_b    (op_b),
        .done    (done),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the word.
    task automatic read_word(input int w, output logic [15:0] v);
        rd_addr = w[4:0];
        @(negedge clk);
        v = rd_data;
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom();
        return r;
    endfunction

    // Monitor: pops the expected product on each done and compares all words.
    initial begin
        forever begin
            @(negedge clk);
            if (done === 1'b1) begin
                logic [511:0] e;
                logic [15:0]  v;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 512'd1, 512'd0);
                end else begin
                    e = exp_q.pop_front();
                    for (int w = 0; w < NRES; w++) begin
                        read_word(w, v);
                        check(v == e[w*16 +: 16], "R4 product word", 512'(v),
                              512'(e[w*16 +: 16]));
                    end
                    last_prod = e;
                end
                mon_cnt++;
            end
        end
    end

    // Driver: pushes the expected product, runs one multiply, checks timing.
    task automatic run_mul(input logic [255:0] a, input logic [255:0] b);
        int  n;
        int  target;
        bit  seen;
        bit  quiet;
        op_a = a;
        op_b = b;
        exp_q.push_back(512'(a) * 512'(b));
        target = mon_cnt + 1;
        hold = 1'b0;
        n = 0;
        seen = 1'b0;
        while (!seen && n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done === 1'b1) seen = 1'b1;
        end
        check(seen && n == RUN_LEN, "R3 done timing", 512'(n), 512'(RUN_LEN));
        quiet = 1'b1;
        for (int k = 0; k < 100 && mon_cnt != target; k++) begin
            @(negedge clk);
            if (done !== 1'b0) quiet = 1'b0;
        end
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done !== 1'b0) quiet = 1'b0;
        end
        check(quiet, "R7 done stays low", 512'(!quiet), 512'd0);
        hold = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] ones;
        logic [15:0]  v;
        bit           quiet;
        ones = '1;

        repeat (3) @(negedge clk);
        check(done === 1'b0, "R1 reset done", 512'(done), 512'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(done === 1'b0, "R1 idle done", 512'(done), 512'd0);

        run_mul('0, rnd256());                              // R4 zero operand
        run_mul(256'd1, 256'd1);                            // R4 word ordering
        run_mul(ones, 256'd1);                              // R4
        run_mul(ones, ones);                                // R5 max carries
        run_mul(256'd1 << 255, 256'd1 << 255);              // R4 top word only
        for (int t = 0; t < 4; t++) run_mul(rnd256(), rnd256()); // R4 random

        // R6: read latency of one cycle.
        rd_addr = 5'd3;
        @(negedge clk);
        rd_addr = 5'd4;
        v = rd_data;
        check(v == last_prod[3*16 +: 16], "R6 old word held", 512'(v),
              512'(last_prod[3*16 +: 16]));
        @(negedge clk);
        v = rd_data;
        check(v == last_prod[4*16 +: 16], "R6 new word", 512'(v),
              512'(last_prod[4*16 +: 16]));

        // R2: hold high with new operands: no done, memory unchanged.
        op_a = rnd256();
        op_b = rnd256();
        quiet = 1'b1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done !== 1'b0) quiet = 1'b0;
        end
        check(quiet, "R2 no done while held", 512'(!quiet), 512'd0);
        for (int w = 0; w < NRES; w++) begin
            read_word(w, v);
            check(v == last_prod[w*16 +: 16], "R2 memory kept", 512'(v),
                  512'(last_prod[w*16 +: 16]));
        end

        // R8: abandon a run midway, then a fresh run must be exact.
        op_a = ones;
        op_b = ones;
        hold = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (done !== 1'b0) quiet = 1'b0;
        end
        hold = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done !== 1'b0) quiet = 1'b0;
        end
        check(quiet, "R8 abandoned run silent", 512'(!quiet), 512'd0);
        run_mul(rnd256(), rnd256());                        // R8 restart
        run_mul(ones, rnd256());                            // R8 R5

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule